// File: doc/BRIEF.md
# Coprocessor Instruction Claim and Command Queue

This block sits on the coprocessor side of a host processor's undefined-instruction handshake. When the host raises its instruction strobe, the block decodes the presented 32-bit word. It claims the word only when the word is addressed to this unit and belongs to a coprocessor class. A claim pulls the active-low absent line low. A busy line holds the host until the unit can take the work.

Internal data operations go into a small first-in first-out queue. They are accepted at once while the queue has room, so the host runs on while an execution engine drains the queue through a valid/ready command port. Register and memory transfers need the results of earlier work. They are therefore held until the queue has fully drained, and are then signalled by a one-cycle start pulse. Privileged words that arrive while the host is in user mode are refused with an abort pulse.

Word fields used by the block: bit 4 is the class bit; bits 11:8 carry the unit number; bits 27:25 give the class (111 data operation, 110 memory transfer, 101 register transfer, any other value is not a coprocessor word); bit 23 marks the word as privileged. All handshake outputs are combinational from the strobe and the word. There is one state bit, which remembers that the current strobe has already been served.

Top module: `cp_handshake`

## Requirements
- R1: Out of reset, and in every cycle where cpi_i is low, cpa_n_o is 1, cpb_o is 0, abort_o is 0 and xfer_go_o is 0. Right after reset, cmd_valid_o is also 0.
- R2: A word is claimed (cpa_n_o = 0 while cpi_i = 1) only when bit 4 is 1, bits 11:8 equal the parameter CP_ID and bits 27:25 are 111, 110 or 101. An unclaimed word leaves cpa_n_o = 1 and cpb_o = 0, and queues nothing.
- R3: A claimed data operation (bits 27:25 = 111) that meets a queue with room sees cpb_o = 0 in the same cycle. The full 32-bit word is queued at that clock edge.
- R4: While the queue holds DEPTH entries, a claimed data operation sees cpb_o = 1 every cycle, and nothing is queued. It is accepted in the first cycle after an entry has been drained.
- R5: If cpi_i falls while cpb_o is high, nothing is queued or started. A later fresh assertion of cpi_i with the same word is handled from the start.
- R6: At most one acceptance occurs per assertion of cpi_i. In the cycles after acceptance while cpi_i stays high, cpa_n_o stays 0, cpb_o stays 0, and nothing further is queued or started.
- R7: A claimed register transfer (101) or memory transfer (110) holds cpb_o = 1 until cmd_valid_o is 0. It is then accepted with a one-cycle xfer_go_o pulse, and xfer_mem_o is 1 for memory and 0 for register.
- R8: A claimed word with bit 23 = 1 that arrives while svc_i = 0 raises abort_o for exactly one cycle with cpb_o = 0. It queues nothing and starts nothing. With svc_i = 1 the same word is handled as in R3 or R7.
- R9: Queued words leave through cmd_o in arrival order. cmd_valid_o is 1 while the queue is not empty, an entry is removed on a clock edge with cmd_valid_o and cmd_ready_i both 1, and the head holds steady while it is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_i | input | 32 | Instruction word presented by the host |
| cpi_i | input | 1 | Host strobe: undefined instruction being offered |
| svc_i | input | 1 | Host is in supervisor mode |
| cpa_n_o | output | 1 | Absent line, low when this unit claims the word |
| cpb_o | output | 1 | Busy line, high while the host must wait |
| abort_o | output | 1 | Refusal of a privileged word in user mode |
| xfer_go_o | output | 1 | One-cycle start of a register or memory transfer |
| xfer_mem_o | output | 1 | With xfer_go_o: 1 memory transfer, 0 register transfer |
| cmd_valid_o | output | 1 | Queue head is valid |
| cmd_o | output | 32 | Queue head word |
| cmd_ready_i | input | 1 | Execution engine takes the head |

## Verification
On every cycle, the assertions check these rules:
- An idle strobe never claims a word.
- A wrong unit number or a clear class bit never claims a word.
- A full queue never takes a push.
- Busy is raised only on a claimed word.
- Transfers start only when the queue is drained.
- Aborts appear only in user mode and never with a push.
- Acceptance never repeats on the next cycle.
- A head that is not taken stays stable.

Other behaviour can only be shown by the bench's scenarios:
- Each word is queued in the right order.
- The exact cycle in which a stalled word is released after a drain.
- Withdrawing the strobe during a stall leaves no stray entry.
- A fresh strobe with the withdrawn word is then accepted at once.

// File: rtl/cph_pkg.sv
package cph_pkg;
  localparam int WORD_W = 32;
  localparam int ID_W   = 4;

  typedef enum logic [1:0] {K_NONE, K_DATA, K_REG, K_MEM} kind_e;

  // class from bits 27:25 gated by the class bit
  function automatic kind_e kind_of(input logic [2:0] cls, input logic cbit);
    if (!cbit) return K_NONE;
    case (cls)
      3'b111:  return K_DATA;
      3'b110:  return K_MEM;
      3'b101:  return K_REG;
      default: return K_NONE;
    endcase
  endfunction

  function automatic logic id_hit(input logic [ID_W-1:0] f, input logic [ID_W-1:0] mine);
    return f == mine;
  endfunction
endpackage

// File: rtl/cph_decode.sv
module cph_decode
  import cph_pkg::*;
#(
  parameter logic [ID_W-1:0] CP_ID = 4'd5
) (
  input  logic [2:0]      cls_f,
  input  logic            cbit_f,
  input  logic [ID_W-1:0] id_f,
  input  logic            priv_f,
  output kind_e           kind,
  output logic            hit,
  output logic            priv
);
  always_comb begin
    kind = kind_of(cls_f, cbit_f);
    hit  = (kind != K_NONE) && id_hit(id_f, CP_ID);
    priv = priv_f;
  end
endmodule

// File: rtl/cph_fifo.sv
module cph_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == FULLC);
  assign dout  = mem[rd_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= bump(wr_q);
      if (pop)  rd_q <= bump(rd_q);
      if (push && !pop)      cnt_q <= cnt_q + 1'b1;
      else if (pop && !push) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end
endmodule

// File: rtl/cp_handshake.sv
module cp_handshake
  import cph_pkg::*;
#(
  parameter logic [ID_W-1:0] CP_ID = 4'd5,
  parameter int              DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] instr_i,
  input  logic              cpi_i,
  input  logic              svc_i,
  output logic              cpa_n_o,
  output logic              cpb_o,
  output logic              abort_o,
  output logic              xfer_go_o,
  output logic              xfer_mem_o,
  output logic              cmd_valid_o,
  output logic [WORD_W-1:0] cmd_o,
  input  logic              cmd_ready_i
);
  kind_e kind;
  logic  hit, priv;
  logic  taken_q;
  logic  offered_w, refuse_w, room_w, accept_w, push_w, pop_w;
  logic  empty_w, full_w;

  cph_decode #(.CP_ID(CP_ID)) u_dec (
    .cls_f  (instr_i[27:25]),
    .cbit_f (instr_i[4]),
    .id_f   (instr_i[11:8]),
    .priv_f (instr_i[23]),
    .kind   (kind),
    .hit    (hit),
    .priv   (priv)
  );

  // data ops need a free slot; transfers need all earlier work drained
  assign offered_w = cpi_i && hit && !taken_q;
  assign refuse_w  = offered_w && priv && !svc_i;
  assign room_w    = (kind == K_DATA) ? !full_w : empty_w;
  assign accept_w  = offered_w && !refuse_w && room_w;
  assign push_w    = accept_w && (kind == K_DATA);
  assign pop_w     = cmd_valid_o && cmd_ready_i;

  assign cpa_n_o    = !(cpi_i && hit);
  assign cpb_o      = offered_w && !refuse_w && !room_w;
  assign abort_o    = refuse_w;
  assign xfer_go_o  = accept_w && (kind != K_DATA);
  assign xfer_mem_o = xfer_go_o && (kind == K_MEM);
  assign cmd_valid_o = !empty_w;

  always_ff @(posedge clk) begin
    if (!rst_n)                    taken_q <= 1'b0;
    else if (!cpi_i)               taken_q <= 1'b0;
    else if (accept_w || refuse_w) taken_q <= 1'b1;
  end

  cph_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_q (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push_w),
    .pop   (pop_w),
    .din   (instr_i),
    .dout  (cmd_o),
    .empty (empty_w),
    .full  (full_w)
  );
endmodule

// File: rtl/cph_check.sv
module cph_check #(
  parameter logic [3:0] CP_ID = 4'd5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cpi_i,
  input logic        svc_i,
  input logic [3:0]  id_f,
  input logic        cbit_f,
  input logic        cpa_n_o,
  input logic        cpb_o,
  input logic        abort_o,
  input logic        xfer_go_o,
  input logic        cmd_valid_o,
  input logic        cmd_ready_i,
  input logic [31:0] cmd_o,
  input logic        push_w,
  input logic        full_w
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpi_i |-> (cpa_n_o && !cpb_o && !abort_o && !xfer_go_o)); // R1
  AST_ID_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpi_i && id_f != CP_ID) |-> cpa_n_o); // R2
  AST_CLASS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpi_i && !cbit_f) |-> cpa_n_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    full_w |-> !push_w); // R4
  AST_BUSY_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
    cpb_o |-> !cpa_n_o); // R4
  AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_w || xfer_go_o) |=> !(push_w || xfer_go_o)); // R6
  AST_XFER_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_go_o |-> !cmd_valid_o); // R7
  AST_ABORT_USER: assert property (@(posedge clk) disable iff (!rst_n)
    abort_o |-> (!svc_i && !cpb_o && !push_w && !xfer_go_o)); // R8
  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid_o && !cmd_ready_i) |=> (cmd_valid_o && $stable(cmd_o))); // R9
endmodule

bind cp_handshake cph_check #(.CP_ID(CP_ID)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpi_i       (cpi_i),
  .svc_i       (svc_i),
  .id_f        (instr_i[11:8]),
  .cbit_f      (instr_i[4]),
  .cpa_n_o     (cpa_n_o),
  .cpb_o       (cpb_o),
  .abort_o     (abort_o),
  .xfer_go_o   (xfer_go_o),
  .cmd_valid_o (cmd_valid_o),
  .cmd_ready_i (cmd_ready_i),
  .cmd_o       (cmd_o),
  .push_w      (push_w),
  .full_w      (full_w)
);

// File: tb/sim_cp_handshake.sv
`timescale 1ns/1ps
module sim_cp_handshake;
  localparam logic [3:0] MY_ID = 4'd5;
  localparam int QD = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] instr = '0;
  logic cpi = 1'b0, svc = 1'b0, rdy = 1'b0;
  logic cpa_n, cpb, abrt, xgo, xmem, cvalid;
  logic [31:0] cmd;

  int n_chk = 0, n_bad = 0;
  logic [31:0] expq [$];

  always #4 clk = ~clk;

  cp_handshake #(.CP_ID(MY_ID), .DEPTH(QD)) u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .cpi_i(cpi), .svc_i(svc),
    .cpa_n_o(cpa_n), .cpb_o(cpb), .abort_o(abrt), .xfer_go_o(xgo),
    .xfer_mem_o(xmem), .cmd_valid_o(cvalid), .cmd_o(cmd), .cmd_ready_i(rdy)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // word builder: cond in 31:28, class 27:25, priv 23, id 11:8, class bit 4
  function automatic logic [31:0] mk(input logic [2:0] cls, input logic [3:0] id,
                                     input logic pv, input logic cb, input logic [7:0] tag);
    logic [31:0] w;
    w = 32'hE000_0000;
    w[27:25] = cls; w[23] = pv; w[11:8] = id; w[4] = cb;
    w[19:12] = tag; w[3:0] = tag[3:0];
    return w;
  endfunction

  // scoreboard monitor: every taken head must match the oldest expected word
  always begin
    @(negedge clk); #3;
    if (rst_n && cvalid && rdy) begin
      if (expq.size() == 0) chk(1'b0, "R9 unexpected command", cmd, 0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk(cmd == e, "R9 queue order", cmd, e);
      end
    end
  end

  // one offer; waits up to maxw busy cycles; checks R6 after acceptance
  task automatic offer(input logic [31:0] w, input int maxw, input logic is_data,
                       output int waited, output logic claimed, output logic acc,
                       output logic ab, output logic xg, output logic xm);
    @(negedge clk); instr = w; cpi = 1'b1; #1;
    claimed = !cpa_n; waited = 0;
    while (claimed && cpb && waited < maxw) begin
      @(negedge clk); #1; waited++;
    end
    acc = claimed && !cpb;
    ab = abrt; xg = xgo; xm = xmem;
    if (acc && is_data && !ab) expq.push_back(w);
    if (!claimed) chk(cpb == 1'b0, "R2 no busy when unclaimed", cpb, 0);
    @(negedge clk); #1;
    if (acc) begin
      chk(!cpa_n && !cpb, "R6 still claimed and not busy", {cpa_n, cpb}, 0);
      chk(!xgo && !abrt, "R6 no second start or abort", {xgo, abrt}, 0);
    end
    cpi = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    int wt; logic cl, ac, ab, xg, xm;
    repeat (3) @(negedge clk);
    #1;
    chk(cpa_n && !cpb && !abrt && !xgo && !cvalid, "R1 reset state",
        {cpa_n, cpb, abrt, xgo, cvalid}, 5'b10000);
    rst_n = 1'b1;

    // R1: matching word but strobe low
    @(negedge clk); instr = mk(3'b111, MY_ID, 0, 1, 8'h11); #1;
    chk(cpa_n && !cpb, "R1 idle strobe no claim", {cpa_n, cpb}, 2'b10);

    // R2: wrong id, class bit clear, bad class field
    offer(mk(3'b111, 4'd3, 0, 1, 8'h21), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(!cl, "R2 id mismatch", cl, 0);
    offer(mk(3'b111, MY_ID, 0, 0, 8'h22), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(!cl, "R2 class bit clear", cl, 0);
    offer(mk(3'b000, MY_ID, 0, 1, 8'h23), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(!cl, "R2 non-coprocessor class", cl, 0);
    #1;
    chk(!cvalid, "R2 nothing queued", cvalid, 0);

    // R3: fill the queue, each accepted without waiting
    for (int i = 0; i < QD; i++) begin
      offer(mk(3'b111, MY_ID, 0, 1, 8'h30 + 8'(i)), 0, 1, wt, cl, ac, ab, xg, xm);
      chk(cl && ac && wt == 0, "R3 immediate accept", {cl, ac, 8'(wt)}, 10'h300);
    end

    // R4: full queue stalls until one entry drains
    fork
      offer(mk(3'b111, MY_ID, 0, 1, 8'h40), 20, 1, wt, cl, ac, ab, xg, xm);
      begin
        repeat (5) @(negedge clk);
        rdy = 1'b1;
        @(negedge clk);
        rdy = 1'b0;
      end
    join
    chk(ac && wt == 5, "R4 released one cycle after drain", wt, 5);

    // R5: withdraw strobe while busy (queue full again)
    offer(mk(3'b111, MY_ID, 0, 1, 8'h50), 3, 1, wt, cl, ac, ab, xg, xm);
    chk(cl && !ac && wt == 3, "R5 still busy when withdrawn", {cl, ac}, 2'b10);
    @(negedge clk); rdy = 1'b1;
    repeat (QD + 2) @(negedge clk);
    #1;
    chk(!cvalid && expq.size() == 0, "R5 no stray entry", cvalid, 0);
    offer(mk(3'b111, MY_ID, 0, 1, 8'h50), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(ac && wt == 0, "R5 fresh strobe accepted", ac, 1);

    // R7: register transfer waits for drain
    repeat (2) @(negedge clk);
    rdy = 1'b0;
    offer(mk(3'b111, MY_ID, 0, 1, 8'h70), 0, 1, wt, cl, ac, ab, xg, xm);
    offer(mk(3'b111, MY_ID, 0, 1, 8'h71), 0, 1, wt, cl, ac, ab, xg, xm);
    fork
      offer(mk(3'b101, MY_ID, 0, 1, 8'h72), 20, 0, wt, cl, ac, ab, xg, xm);
      begin
        repeat (3) @(negedge clk);
        rdy = 1'b1;
      end
    join
    chk(ac && xg && !xm && wt == 4, "R7 register transfer after drain",
        {xg, xm, 8'(wt)}, 10'h204);
    offer(mk(3'b110, MY_ID, 0, 1, 8'h73), 5, 0, wt, cl, ac, ab, xg, xm);
    chk(ac && xg && xm && wt == 0, "R7 memory transfer", {xg, xm, 8'(wt)}, 10'h300);

    // R8: privileged word in user mode aborts, in supervisor mode proceeds
    svc = 1'b0;
    offer(mk(3'b111, MY_ID, 1, 1, 8'h80), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(cl && ab && !xg, "R8 abort in user mode", {cl, ab, xg}, 3'b110);
    #1;
    chk(!cvalid && !abrt, "R8 nothing queued, abort one cycle", {cvalid, abrt}, 0);
    offer(mk(3'b110, MY_ID, 1, 1, 8'h81), 0, 0, wt, cl, ac, ab, xg, xm);
    chk(ab && !xg, "R8 transfer refused in user mode", {ab, xg}, 2'b10);
    svc = 1'b1;
    offer(mk(3'b111, MY_ID, 1, 1, 8'h82), 0, 1, wt, cl, ac, ab, xg, xm);
    chk(ac && !ab, "R8 supervisor accepted", {ac, ab}, 2'b10);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R9 all queued words delivered", expq.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule